// File: doc/BRIEF.md
# Dual-Channel Sample Pair Serializer

This block accepts one sample from channel A and one from channel B together, marked by a valid strobe. It spreads the pair over a bank of output lanes, one bit group per lane, and sends each group most significant bit first. Each lane has two slots per fast-clock cycle: a rise slot and a fall slot. An output cell placed later turns these into a double-rate pin, so the block itself uses a single clock edge. A bit-clock enable is high while a pair is on the lanes. A frame marker toggles at each frame start.

Configuration inputs set four things: the word resolution (8, 10, 12 or 16 bits), the edge mode (full double rate, half double rate or single rate), the ordering used in full double rate (interleaved or channel-sequential), and, for 16-bit words, the lane count (8, 4 or 2). A frame is as many sample pairs as there are bits per lane. The configuration is sampled only when the first pair of a frame is accepted. A new pair is taken only once the current pair is finishing. A pair that arrives earlier is dropped and sets a sticky overflow flag.

Top module: `pair_serializer`

## Requirements
- R1: After reset, `lane_rise`, `lane_fall`, `bit_en`, `frame_mark` and `overflow` are all 0. With every configuration input at 0, the block runs 10-bit words in interleaved full double rate.
- R2: Resolution codes are 0 for 10 bits, 1 for 12, 2 for 16 and 3 for 8. The input word sits in its low bits and the bits above the resolution are ignored. Below 16 bits, lanes 0 to res/2-1 carry 2 bits each. At 16 bits, lane codes 0, 1 and 2-or-3 select 8, 4 or 2 lanes of 2, 4 or 8 bits. Lane 0 carries the most significant group. Unused lanes are 0.
- R3: Edge code 0 (and 3), ordering 0: in slot cycle k of bpl cycles, the rise bit of lane i is bit k of channel A's group and the fall bit is bit k of channel B's group, MSB first.
- R4: Edge code 0, ordering 1: each lane sends its A group followed by its B group. Stream bit 2k goes in the rise slot and bit 2k+1 in the fall slot, over bpl cycles.
- R5: Edge code 1: channel A uses lanes 0-7 and channel B uses lanes 8-15. Lane i sends group bit 2k in the rise slot and 2k+1 in the fall slot, over bpl/2 cycles. Lanes 8-15 are 0 in every other mode.
- R6: Edge code 2: each lane sends its A group then its B group, one bit per cycle over 2*bpl cycles, and the fall slot repeats the rise slot.
- R7: `bit_en` is high for exactly the pair's slot cycles, starting the cycle after acceptance. While it is low, all lane outputs are 0.
- R8: A strobe during a pair's last slot cycle is accepted back-to-back. A strobe during any earlier busy cycle drops that pair and sets `overflow`, which stays set until reset.
- R9: `frame_mark` toggles when the first pair of each frame is accepted. A frame holds bpl pairs.
- R10: Configuration inputs are sampled only when a frame's first pair is accepted. Changes at other times have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_res | input | 2 | Resolution code |
| cfg_edge | input | 2 | Edge mode code |
| cfg_seq | input | 1 | Full double rate ordering: 0 interleaved, 1 sequential |
| cfg_lanes | input | 2 | Lane count code for 16-bit words |
| in_vld | input | 1 | Sample pair valid strobe |
| in_a | input | 16 | Channel A sample, low-bit aligned |
| in_b | input | 16 | Channel B sample, low-bit aligned |
| lane_rise | output | 16 | Rise-slot bit per lane (lanes 8-15 used in half double rate) |
| lane_fall | output | 16 | Fall-slot bit per lane |
| bit_en | output | 1 | Bit clock enable, high while a pair is on the lanes |
| frame_mark | output | 1 | Frame marker, toggles at each frame start |
| overflow | output | 1 | Sticky flag for a dropped pair |

## Verification
Two events can fall in the same cycle. A new pair can arrive on the last slot cycle of the current pair, when acceptance and completion coincide. A strobe can also arrive in a middle slot, when a rejected pair meets shifting that is still under way. The bench provokes the first by raising the strobe exactly on the final slot of open-ended random sends. It judges that case by checking that `bit_en` never drops and that the next slot shows the new pair's first bits. It provokes the second by pulsing the strobe with different data in slot 2. It judges that case by checking that the running pair's bits are unchanged, that `overflow` sets, and that no further pair follows.

// File: rtl/pser_pkg.sv
package pser_pkg;

    localparam int WORD_W     = 16;
    localparam int BANK_LANES = 8;
    localparam int GEO_W      = 5;

    typedef enum logic [1:0] {
        RES_10 = 2'd0,
        RES_12 = 2'd1,
        RES_16 = 2'd2,
        RES_8  = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        EDGE_DDR  = 2'd0,
        EDGE_HALF = 2'd1,
        EDGE_SDR  = 2'd2,
        EDGE_ALT  = 2'd3
    } edge_e;

    typedef struct packed {
        res_e       res;
        edge_e      edge_m;
        logic       seq;
        logic [1:0] lanes;
    } cfg_t;

endpackage

// File: rtl/pser_geom.sv
module pser_geom
    import pser_pkg::*;
#(
    parameter int GW = GEO_W
) (
    input  cfg_t          cfg,
    output logic [GW-1:0] width,
    output logic [GW-1:0] bpl,
    output logic [GW-1:0] nlanes,
    output logic [GW-1:0] ncyc
);

    always_comb begin
        unique case (cfg.res)
            RES_8:   width = GW'(8);
            RES_10:  width = GW'(10);
            RES_12:  width = GW'(12);
            default: width = GW'(16);
        endcase

        if (cfg.res != RES_16) begin
            bpl    = GW'(2);
            nlanes = width >> 1;
        end else begin
            unique case (cfg.lanes)
                2'd0: begin bpl = GW'(2); nlanes = GW'(8); end
                2'd1: begin bpl = GW'(4); nlanes = GW'(4); end
                default: begin bpl = GW'(8); nlanes = GW'(2); end
            endcase
        end

        unique case (cfg.edge_m)
            EDGE_HALF: ncyc = bpl >> 1;
            EDGE_SDR:  ncyc = bpl << 1;
            default:   ncyc = bpl;
        endcase
    end

endmodule

// File: rtl/pser_slot_mux.sv
module pser_slot_mux
    import pser_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int NL = BANK_LANES,
    parameter int GW = GEO_W
) (
    input  logic            active,
    input  edge_e           edge_m,
    input  logic            seq_ord,
    input  logic [GW-1:0]   bpl,
    input  logic [GW-1:0]   nlanes,
    input  logic [GW-1:0]   cnt,
    input  logic [WW-1:0]   wa,
    input  logic [WW-1:0]   wb,
    output logic [2*NL-1:0] rise,
    output logic [2*NL-1:0] fall
);

    localparam int IW = $clog2(WW);

    function automatic logic grp_bit(input logic [WW-1:0] w, input int lane,
                                     input int j, input int b);
        int pos;
        logic [IW-1:0] p;
        pos = WW - 1 - lane * b - j;
        if (pos < 0 || pos >= WW) return 1'b0;
        p = IW'(pos);
        return w[p];
    endfunction

    function automatic logic stream_bit(input logic [WW-1:0] x, input logic [WW-1:0] y,
                                        input int lane, input int s, input int b);
        if (s < b) return grp_bit(x, lane, s, b);
        return grp_bit(y, lane, s - b, b);
    endfunction

    for (genvar gi = 0; gi < NL; gi++) begin : g_lane
        logic r_a, f_a, r_b, f_b;

        always_comb begin
            int b;
            int k;
            b   = int'(bpl);
            k   = int'(cnt);
            r_a = 1'b0;
            f_a = 1'b0;
            r_b = 1'b0;
            f_b = 1'b0;
            if (active && (gi < int'(nlanes))) begin
                unique case (edge_m)
                    EDGE_HALF: begin
                        r_a = grp_bit(wa, gi, 2 * k, b);
                        f_a = grp_bit(wa, gi, 2 * k + 1, b);
                        r_b = grp_bit(wb, gi, 2 * k, b);
                        f_b = grp_bit(wb, gi, 2 * k + 1, b);
                    end
                    EDGE_SDR: begin
                        r_a = stream_bit(wa, wb, gi, k, b);
                        f_a = r_a;
                    end
                    default: begin
                        if (seq_ord) begin
                            r_a = stream_bit(wa, wb, gi, 2 * k, b);
                            f_a = stream_bit(wa, wb, gi, 2 * k + 1, b);
                        end else begin
                            r_a = grp_bit(wa, gi, k, b);
                            f_a = grp_bit(wb, gi, k, b);
                        end
                    end
                endcase
            end
        end

        assign rise[gi]      = r_a;
        assign fall[gi]      = f_a;
        assign rise[gi + NL] = r_b;
        assign fall[gi + NL] = f_b;
    end

endmodule

// File: rtl/pair_serializer.sv
module pair_serializer
    import pser_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int NL = BANK_LANES,
    parameter int GW = GEO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cfg_res,
    input  logic [1:0]      cfg_edge,
    input  logic            cfg_seq,
    input  logic [1:0]      cfg_lanes,
    input  logic            in_vld,
    input  logic [WW-1:0]   in_a,
    input  logic [WW-1:0]   in_b,
    output logic [2*NL-1:0] lane_rise,
    output logic [2*NL-1:0] lane_fall,
    output logic            bit_en,
    output logic            frame_mark,
    output logic            overflow
);

    typedef struct packed {
        logic          busy;
        logic [GW-1:0] cnt;
        logic [GW-1:0] pidx;
        cfg_t          cfg;
        logic [WW-1:0] wa;
        logic [WW-1:0] wb;
        logic          frame;
        logic          ovf;
    } state_t;

    state_t state_d, state_q;

    cfg_t cfg_in, cfg_use;
    logic [GW-1:0] act_width, act_bpl, act_nl, act_ncyc;
    logic [GW-1:0] use_width, use_bpl, use_nl, use_ncyc;
    logic last_slot, accept, frame_start;

    assign cfg_in      = '{res: res_e'(cfg_res), edge_m: edge_e'(cfg_edge),
                           seq: cfg_seq, lanes: cfg_lanes};
    assign frame_start = (state_q.pidx == '0);
    assign cfg_use     = frame_start ? cfg_in : state_q.cfg;

    pser_geom #(.GW(GW)) u_geom_act (
        .cfg(state_q.cfg), .width(act_width), .bpl(act_bpl),
        .nlanes(act_nl), .ncyc(act_ncyc)
    );

    pser_geom #(.GW(GW)) u_geom_use (
        .cfg(cfg_use), .width(use_width), .bpl(use_bpl),
        .nlanes(use_nl), .ncyc(use_ncyc)
    );

    function automatic logic [WW-1:0] align_word(input logic [WW-1:0] x,
                                                 input logic [GW-1:0] w);
        logic [WW-1:0] m;
        m = '1;
        m = m >> (WW - int'(w));
        return (x & m) << (WW - int'(w));
    endfunction

    assign last_slot = state_q.busy && (state_q.cnt == act_ncyc - GW'(1));
    assign accept    = in_vld && (!state_q.busy || last_slot);

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d.busy  = 1'b1;
            state_d.cnt   = '0;
            state_d.cfg   = cfg_use;
            state_d.wa    = align_word(in_a, use_width);
            state_d.wb    = align_word(in_b, use_width);
            state_d.frame = state_q.frame ^ frame_start;
            state_d.pidx  = (state_q.pidx + GW'(1) >= use_bpl) ? '0 : state_q.pidx + GW'(1);
        end else if (state_q.busy) begin
            if (last_slot) begin
                state_d.busy = 1'b0;
                state_d.cnt  = '0;
            end else begin
                state_d.cnt = state_q.cnt + GW'(1);
            end
        end
        if (in_vld && state_q.busy && !last_slot) state_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    pser_slot_mux #(.WW(WW), .NL(NL), .GW(GW)) u_mux (
        .active(state_q.busy), .edge_m(state_q.cfg.edge_m), .seq_ord(state_q.cfg.seq),
        .bpl(act_bpl), .nlanes(act_nl), .cnt(state_q.cnt),
        .wa(state_q.wa), .wb(state_q.wb), .rise(lane_rise), .fall(lane_fall)
    );

    assign bit_en     = state_q.busy;
    assign frame_mark = state_q.frame;
    assign overflow   = state_q.ovf;

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |-> (lane_rise == '0 && lane_fall == '0));

    assert_slot_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.busy |-> (state_q.cnt < act_ncyc));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_early_strobe_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && bit_en && !last_slot) |=> overflow);

    assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_mark != $past(frame_mark)) |-> (bit_en && state_q.cnt == '0));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.pidx != '0) |=> (state_q.cfg == $past(state_q.cfg)));

    assert_sdr_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state_q.cfg.edge_m == EDGE_SDR) |-> (lane_rise == lane_fall));

    assert_bank_b_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cfg.edge_m != EDGE_HALF) |->
        (lane_rise[2*NL-1:NL] == '0 && lane_fall[2*NL-1:NL] == '0));

endmodule

// File: tb/pair_serializer_test.sv
module pair_serializer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_res = '0, cfg_edge = '0, cfg_lanes = '0;
    logic        cfg_seq = 1'b0;
    logic        in_vld = 1'b0;
    logic [15:0] in_a = '0, in_b = '0;
    logic [15:0] lane_rise, lane_fall;
    logic        bit_en, frame_mark, overflow;

    int checks = 0;
    int fails  = 0;
    int m_res = 0, m_ed = 0, m_sq = 0, m_ln = 0, m_pidx = 0;
    bit m_frame = 1'b0;

    always #2 clk = ~clk;

    pair_serializer uut (
        .clk(clk), .rst_n(rst_n), .cfg_res(cfg_res), .cfg_edge(cfg_edge),
        .cfg_seq(cfg_seq), .cfg_lanes(cfg_lanes), .in_vld(in_vld),
        .in_a(in_a), .in_b(in_b), .lane_rise(lane_rise), .lane_fall(lane_fall),
        .bit_en(bit_en), .frame_mark(frame_mark), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int f_width(input int res);
        case (res)
            0: return 10;
            1: return 12;
            2: return 16;
            default: return 8;
        endcase
    endfunction

    function automatic int f_bpl(input int res, input int ln);
        if (res != 2) return 2;
        if (ln == 0) return 2;
        if (ln == 1) return 4;
        return 8;
    endfunction

    function automatic int f_ncyc(input int res, input int ln, input int ed);
        int b;
        b = f_bpl(res, ln);
        if (ed == 1) return b / 2;
        if (ed == 2) return 2 * b;
        return b;
    endfunction

    function automatic logic [31:0] f_slot(input logic [15:0] a, input logic [15:0] b,
                                           input int res, input int ed, input int sq,
                                           input int ln, input int k);
        logic [15:0] ua, ub, r, f;
        logic [15:0] sa [16];
        logic [15:0] sb [16];
        int w, bp, nl;
        w  = f_width(res);
        bp = f_bpl(res, ln);
        nl = (res != 2) ? w / 2 : 16 / bp;
        ua = (a & 16'((32'h1 << w) - 1)) << (16 - w);
        ub = (b & 16'((32'h1 << w) - 1)) << (16 - w);
        r = '0;
        f = '0;
        for (int i = 0; i < 16; i++) begin
            sa[i] = '0;
            sb[i] = '0;
        end
        for (int i = 0; i < nl; i++)
            for (int j = 0; j < bp; j++) begin
                sa[i][j] = ua[15 - i * bp - j];
                sb[i][j] = ub[15 - i * bp - j];
            end
        for (int i = 0; i < nl; i++) begin
            if (ed == 1) begin
                r[i]     = sa[i][2 * k];
                f[i]     = sa[i][2 * k + 1];
                r[i + 8] = sb[i][2 * k];
                f[i + 8] = sb[i][2 * k + 1];
            end else if (ed == 2) begin
                r[i] = (k < bp) ? sa[i][k] : sb[i][k - bp];
                f[i] = r[i];
            end else if (sq != 0) begin
                r[i] = (2 * k < bp) ? sa[i][2 * k] : sb[i][2 * k - bp];
                f[i] = (2 * k + 1 < bp) ? sa[i][2 * k + 1] : sb[i][2 * k + 1 - bp];
            end else begin
                r[i] = sa[i][k];
                f[i] = sb[i][k];
            end
        end
        return {r, f};
    endfunction

    task automatic send(input logic [15:0] a, input logic [15:0] b, input int res,
                        input int ed, input int sq, input int ln, input string tag,
                        input bit open, input int inj);
        int n, bp;
        string t;
        logic [31:0] exp;
        cfg_res   = 2'(res);
        cfg_edge  = 2'(ed);
        cfg_seq   = 1'(sq);
        cfg_lanes = 2'(ln);
        in_a = a;
        in_b = b;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        if (m_pidx == 0) begin
            m_res = res; m_ed = ed; m_sq = sq; m_ln = ln;
            m_frame = ~m_frame;
        end
        n  = f_ncyc(m_res, m_ln, m_ed);
        bp = f_bpl(m_res, m_ln);
        m_pidx = (m_pidx + 1) % bp;
        if (tag != "") t = tag;
        else if (m_ed == 1) t = "R5";
        else if (m_ed == 2) t = "R6";
        else if (m_sq != 0) t = "R4";
        else t = "R3";
        for (int k = 0; k < n; k++) begin
            if (k == inj + 1) in_vld = 1'b0;
            exp = f_slot(a, b, m_res, m_ed, m_sq, m_ln, k);
            chk(bit_en == 1'b1 && {lane_rise, lane_fall} == exp, t, "slot lanes",
                {lane_rise, lane_fall}, exp);
            if (k == 0) chk(frame_mark == m_frame, "R9", "frame marker",
                            32'(frame_mark), 32'(m_frame));
            if (k == inj) begin
                in_vld = 1'b1;
                in_a = ~a;
                in_b = ~b;
            end
            if (k < n - 1 || !open) @(negedge clk);
        end
        if (!open)
            chk(bit_en == 1'b0 && lane_rise == '0 && lane_fall == '0, "R7",
                "idle after pair", {lane_rise, lane_fall}, 32'h0);
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] ra, rb;
        bit prev_open;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(lane_rise == '0 && lane_fall == '0 && !bit_en && !frame_mark && !overflow,
            "R1", "reset outputs", {lane_rise, lane_fall}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bit_en && !frame_mark, "R1", "idle after reset", {30'h0, bit_en, frame_mark}, 32'h0);

        // R1: all-zero configuration gives 10-bit interleaved DDR
        send(16'hF2B7, 16'h0159, 0, 0, 0, 0, "R1", 1'b0, -1);
        send(16'h0333, 16'h02CC, 0, 0, 0, 0, "R3", 1'b0, -1);
        // R2: 8-bit words on 4 lanes, upper input bits ignored
        send(16'hFFA5, 16'h773C, 3, 0, 0, 0, "R2", 1'b0, -1);
        send(16'h0081, 16'h0042, 3, 0, 0, 0, "R2", 1'b0, -1);

        // R8: back-to-back acceptance on the last slot
        while (m_pidx != 0) send(16'h1234, 16'h4321, 0, 0, 0, 0, "", 1'b0, -1);
        send(16'hBEEF, 16'h5A5A, 2, 0, 1, 1, "R8", 1'b1, -1);
        send(16'h0F0F, 16'hC3C3, 2, 0, 1, 1, "R8", 1'b0, -1);

        prev_open = 1'b0;
        for (int it = 0; it < 160; it++) begin
            bit op;
            ra = 16'($urandom);
            rb = 16'($urandom);
            op = (it < 159) && (($urandom % 4) == 0);
            send(ra, rb, int'($urandom % 4), int'($urandom % 4), int'($urandom % 2),
                 int'($urandom % 4), prev_open ? "R8" : "", op, -1);
            prev_open = op;
        end

        // R10: mid-frame configuration change has no effect
        while (m_pidx != 0) send(16'h5555, 16'hAAAA, 2, 0, 0, 2, "", 1'b0, -1);
        send(16'h9C3E, 16'h61D0, 2, 0, 0, 2, "R10", 1'b0, -1);
        send(16'h1357, 16'h2468, 3, 2, 1, 0, "R10", 1'b0, -1);
        chk(overflow == 1'b0, "R8", "no overflow yet", 32'(overflow), 32'h0);

        // R8: strobe in a middle slot is dropped and flags overflow
        send(16'hE1D2, 16'h0C3B, 3, 2, 1, 0, "R8", 1'b0, 2);
        chk(overflow == 1'b1, "R8", "overflow set", 32'(overflow), 32'h1);
        repeat (3) @(negedge clk);
        chk(overflow == 1'b1 && !bit_en, "R8", "sticky and pair dropped",
            {30'h0, overflow, bit_en}, 32'h2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule